// File: doc/BRIEF.md
# Privileged Instruction Trap Checker

This block sits beside the decode stage and decides, for each decoded instruction, whether an illegal-instruction trap must be raised. It looks at the instruction class, the CSR address, the low two bits of the CSR function code, the rs1/uimm field, the current privilege level and the trap-wait control. It answers in the same cycle with a trap flag and a cause code.

The block also owns the floating-point state field of the machine status word and its summary-dirty bit. Any accepted write to one of the three floating-point CSRs moves the field to dirty. So does a floating-point register write while the unit is enabled. The CSR file may load a new value into the field.

The set of implemented CSR addresses is a parameter table. Read-only status and minimum privilege are decoded from the address itself.

Top module: `pt_trap_check`

## Requirements
- R1: A CSR instruction (kind 2'b01) whose address is not in the implemented table traps. The default table holds 001, 002, 003, 100, 180, 300, 301, 305, 341, 342, C00, C02 and F14 (hex).
- R2: With the FP state field at 2'b00, a floating-point register instruction (kind 2'b10) traps. A CSR instruction addressing 001, 002 or 003 also traps.
- R3: A CSR instruction that writes a CSR whose address bits [11:10] are 2'b11 traps.
- R4: A CSR instruction writes when its function bits are 2'b01 (swap), or when rs1/uimm is nonzero. Set (2'b10) and clear (2'b11) with rs1 zero are reads and do not trap on a read-only CSR.
- R5: A CSR instruction traps when the privilege (U=0, S=1, M=3) is numerically below address bits [9:8].
- R6: A wait-for-interrupt instruction (kind 2'b11) traps when the trap-wait input is 1 and the privilege is not 3.
- R7: The trap output is combinational and is 0 when in_valid is 0 or kind is 2'b00. The cause is 2 when trap is 1 and 0 otherwise.
- R8: After reset the FP state field is 2'b01 and the dirty summary is 0.
- R9: A CSR write to 001, 002 or 003 that does not trap sets the field to 2'b11 at the next edge, and the summary then reads 1. A trapped write leaves the field unchanged.
- R10: A floating-point register write sets the field to 2'b11 at the next edge when the field is nonzero. It is ignored when the field is 2'b00.
- R11: A field load writes the loaded value at the next edge. When a dirtying event occurs in the same cycle, dirty (2'b11) wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is present |
| in_kind | input | 2 | 00 other, 01 CSR, 10 FP register op, 11 wait-for-interrupt |
| csr_addr | input | 12 | CSR address field |
| csr_fn | input | 2 | Low two function bits: 01 swap, 10 set, 11 clear |
| rs1_idx | input | 5 | rs1 index or immediate field |
| cur_priv | input | 2 | Current privilege level |
| tw_bit | input | 1 | Trap-wait control |
| fs_load | input | 1 | Load the FP state field |
| fs_load_val | input | 2 | Value to load |
| fpu_rf_write | input | 1 | Floating-point register write |
| trap | output | 1 | Illegal-instruction trap |
| trap_cause | output | 4 | Cause code |
| fs | output | 2 | FP state field |
| sd | output | 1 | Dirty summary bit |

## Verification
The trap flag and cause are combinational, so they are due in the cycle the instruction is presented. The bench drives inputs on the falling edge and compares trap and cause one time step later, before the next rising edge. FP state and the dirty summary change at the rising edge after the event. They are compared one time step after that edge against a bench model that is advanced at the same point. Random instructions with a fixed seed follow directed cases for each trap reason and each field update rule.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int unsigned CSR_AW  = 12;
  localparam int unsigned CAUSE_W = 4;

  typedef enum logic [1:0] {
    K_OTHER = 2'b00,
    K_CSR   = 2'b01,
    K_FPOP  = 2'b10,
    K_WFI   = 2'b11
  } kind_e;

  localparam logic [1:0] PRIV_M = 2'b11;
  localparam logic [1:0] FS_OFF = 2'b00;
  localparam logic [1:0] FS_INI = 2'b01;
  localparam logic [1:0] FS_DRT = 2'b11;
  localparam logic [CAUSE_W-1:0] CAUSE_ILL = 4'd2;
endpackage

// File: rtl/pt_csr_lookup.sv
module pt_csr_lookup #(
  parameter int unsigned AW    = 12,
  parameter int unsigned N_CSR = 13,
  parameter logic [N_CSR-1:0][AW-1:0] CSR_LIST = '0
) (
  input  logic [AW-1:0] addr,
  output logic          exists,
  output logic          read_only,
  output logic [1:0]    min_priv,
  output logic          is_fp_csr
);
  logic [N_CSR-1:0] hit;

  for (genvar gi = 0; gi < N_CSR; gi++) begin : g_match
    assign hit[gi] = (addr == CSR_LIST[gi]);
  end

  assign exists    = |hit;
  assign read_only = (addr[AW-1 -: 2] == 2'b11);
  assign min_priv  = addr[AW-3 -: 2];
  assign is_fp_csr = (addr[AW-1:2] == '0) && (addr[1:0] != 2'b00);
endmodule

// File: rtl/pt_trap_decide.sv
module pt_trap_decide
  import pt_pkg::*;
(
  input  logic               in_valid,
  input  logic [1:0]         in_kind,
  input  logic [1:0]         csr_fn,
  input  logic [4:0]         rs1_idx,
  input  logic [1:0]         cur_priv,
  input  logic               tw_bit,
  input  logic [1:0]         fs_cur,
  input  logic               exists,
  input  logic               read_only,
  input  logic [1:0]         min_priv,
  input  logic               is_fp_csr,
  output logic               csr_writes,
  output logic               trap,
  output logic [CAUSE_W-1:0] cause
);
  logic fp_off;
  logic csr_bad;

  always_comb begin
    fp_off     = (fs_cur == FS_OFF);
    csr_writes = (csr_fn == 2'b01) || (rs1_idx != 5'd0);
    csr_bad    = !exists
               || (cur_priv < min_priv)
               || (read_only && csr_writes)
               || (is_fp_csr && fp_off);
    trap = 1'b0;
    if (in_valid) begin
      unique case (kind_e'(in_kind))
        K_CSR:   trap = csr_bad;
        K_FPOP:  trap = fp_off;
        K_WFI:   trap = tw_bit && (cur_priv != PRIV_M);
        default: trap = 1'b0;
      endcase
    end
    cause = trap ? CAUSE_ILL : '0;
  end
endmodule

// File: rtl/pt_fs_state.sv
module pt_fs_state
  import pt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_dirty,
  input  logic       load_en,
  input  logic [1:0] load_val,
  output logic [1:0] fs_q
);
  logic [1:0] fs_d;
  logic       fs_en;

  always_comb begin
    fs_en = set_dirty || load_en;
    fs_d  = set_dirty ? FS_DRT : load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fs_q <= FS_INI;
    else if (fs_en) fs_q <= fs_d;
  end
endmodule

// File: rtl/pt_trap_check.sv
module pt_trap_check
  import pt_pkg::*;
#(
  parameter int unsigned N_CSR = 13,
  parameter logic [N_CSR-1:0][CSR_AW-1:0] CSR_LIST = {
    12'hF14, 12'hC02, 12'hC00, 12'h342, 12'h341, 12'h305, 12'h301,
    12'h300, 12'h180, 12'h100, 12'h003, 12'h002, 12'h001}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         in_kind,
  input  logic [CSR_AW-1:0]  csr_addr,
  input  logic [1:0]         csr_fn,
  input  logic [4:0]         rs1_idx,
  input  logic [1:0]         cur_priv,
  input  logic               tw_bit,
  input  logic               fs_load,
  input  logic [1:0]         fs_load_val,
  input  logic               fpu_rf_write,
  output logic               trap,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [1:0]         fs,
  output logic               sd
);
  logic       exists, read_only, is_fp_csr, csr_writes;
  logic [1:0] min_priv;
  logic       fp_csr_wr, fp_rf_dirty, set_dirty;

  pt_csr_lookup #(.AW(CSR_AW), .N_CSR(N_CSR), .CSR_LIST(CSR_LIST)) u_lookup (
    .addr(csr_addr), .exists(exists), .read_only(read_only),
    .min_priv(min_priv), .is_fp_csr(is_fp_csr)
  );

  pt_trap_decide u_decide (
    .in_valid(in_valid), .in_kind(in_kind), .csr_fn(csr_fn),
    .rs1_idx(rs1_idx), .cur_priv(cur_priv), .tw_bit(tw_bit),
    .fs_cur(fs), .exists(exists), .read_only(read_only),
    .min_priv(min_priv), .is_fp_csr(is_fp_csr),
    .csr_writes(csr_writes), .trap(trap), .cause(trap_cause)
  );

  always_comb begin
    fp_csr_wr   = in_valid && (in_kind == K_CSR) && is_fp_csr
                  && csr_writes && !trap;
    fp_rf_dirty = fpu_rf_write && (fs != FS_OFF);
    set_dirty   = fp_csr_wr || fp_rf_dirty;
  end

  pt_fs_state u_fs (
    .clk(clk), .rst_n(rst_n), .set_dirty(set_dirty),
    .load_en(fs_load), .load_val(fs_load_val), .fs_q(fs)
  );

  assign sd = (fs == FS_DRT);
endmodule

// File: rtl/pt_trap_check_sva.sv
module pt_trap_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  in_kind,
  input logic [11:0] csr_addr,
  input logic [1:0]  csr_fn,
  input logic [4:0]  rs1_idx,
  input logic [1:0]  cur_priv,
  input logic        tw_bit,
  input logic        fs_load,
  input logic        fpu_rf_write,
  input logic        trap,
  input logic [3:0]  trap_cause,
  input logic [1:0]  fs,
  input logic        sd
);
  logic wr_like, fp_addr;
  assign wr_like = (csr_fn == 2'b01) || (rs1_idx != 5'd0);
  assign fp_addr = (csr_addr == 12'h001) || (csr_addr == 12'h002) || (csr_addr == 12'h003);

  // R1
  unimpl_csr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'b01 && csr_addr == 12'h7C0) |-> trap);

  // R2
  fp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'b10 && fs == 2'b00) |-> trap);

  // R3
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'b01 && csr_addr[11:10] == 2'b11 && wr_like) |-> trap);

  // R6
  wfi_tw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'b11 && tw_bit && cur_priv != 2'b11) |-> trap);

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || in_kind == 2'b00) |-> !trap);

  // R7
  cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_cause == (trap ? 4'd2 : 4'd0));

  // R9
  fp_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'b01 && fp_addr && wr_like && !trap) |=> (fs == 2'b11 && sd));

  // R10
  rf_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fpu_rf_write && fs == 2'b00 && !fs_load && !(in_valid && in_kind == 2'b01 && !trap))
    |=> $stable(fs));
endmodule

bind pt_trap_check pt_trap_check_sva u_sva (.*);

// File: tb/pt_trap_check_bench.sv
module pt_trap_check_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, tw_bit, fs_load, fpu_rf_write;
  logic [1:0] in_kind, csr_fn, cur_priv, fs_load_val;
  logic [11:0] csr_addr;
  logic [4:0] rs1_idx;
  logic trap, sd;
  logic [3:0] trap_cause;
  logic [1:0] fs;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [1:0] m_fs;
  logic [11:0] impl_tab [13] = '{12'h001, 12'h002, 12'h003, 12'h100, 12'h180,
    12'h300, 12'h301, 12'h305, 12'h341, 12'h342, 12'hC00, 12'hC02, 12'hF14};

  always #(CLK_P/2) clk = ~clk;

  pt_trap_check u_pt_trap_check (.*);

  function automatic logic is_impl(input logic [11:0] a);
    for (int i = 0; i < 13; i++) if (impl_tab[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic is_fpc(input logic [11:0] a);
    return (a == 12'h001) || (a == 12'h002) || (a == 12'h003);
  endfunction

  function automatic logic writes(input logic [1:0] f, input logic [4:0] r);
    return (f == 2'b01) || (r != 0);
  endfunction

  function automatic logic exp_trap(input logic v, input logic [1:0] k,
      input logic [11:0] a, input logic [1:0] f, input logic [4:0] r,
      input logic [1:0] p, input logic t, input logic [1:0] s);
    if (!v) return 1'b0;
    case (k)
      2'b01: return !is_impl(a) || (p < a[9:8]) || (a[11:10] == 2'b11 && writes(f, r))
                    || (is_fpc(a) && s == 2'b00);
      2'b10: return s == 2'b00;
      2'b11: return t && p != 2'b11;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [1:0] k,
      input logic [11:0] a, input logic [1:0] f, input logic [4:0] r,
      input logic [1:0] p, input logic t, input logic ld, input logic [1:0] ldv,
      input logic fw);
    logic et;
    logic [1:0] nfs;
    @(negedge clk);
    in_valid = v; in_kind = k; csr_addr = a; csr_fn = f; rs1_idx = r;
    cur_priv = p; tw_bit = t; fs_load = ld; fs_load_val = ldv; fpu_rf_write = fw;
    #1;
    et = exp_trap(v, k, a, f, r, p, t, m_fs);
    check({tag, " trap"}, int'(trap), int'(et));
    check({tag, " cause"}, int'(trap_cause), et ? 2 : 0);
    nfs = ld ? ldv : m_fs;
    if ((v && k == 2'b01 && is_fpc(a) && writes(f, r) && !et) || (fw && m_fs != 2'b00))
      nfs = 2'b11;
    @(posedge clk);
    #1;
    m_fs = nfs;
    check({tag, " fs"}, int'(fs), int'(m_fs));
    check({tag, " sd"}, int'(sd), int'(m_fs == 2'b11));
  endtask

  initial begin
    while (cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected below 200000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] ra;
    void'($urandom(32'd4711));
    rst_n = 1'b0; in_valid = 0; in_kind = 0; csr_addr = 0; csr_fn = 0;
    rs1_idx = 0; cur_priv = 0; tw_bit = 0; fs_load = 0; fs_load_val = 0;
    fpu_rf_write = 0; m_fs = 2'b01;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset fs", int'(fs), 1);
    check("R8 reset sd", int'(sd), 0);
    @(negedge clk) rst_n = 1'b1;

    step("R1 unimpl",       1, 2'b01, 12'h7C0, 2'b10, 5'd0, 2'b11, 0, 0, 0, 0);
    step("R1 impl",         1, 2'b01, 12'h341, 2'b01, 5'd3, 2'b11, 0, 0, 0, 0);
    step("R2 fp on",        1, 2'b10, 12'h000, 2'b00, 5'd0, 2'b00, 0, 1, 2'b00, 0);
    step("R2 fp off",       1, 2'b10, 12'h000, 2'b00, 5'd0, 2'b00, 0, 0, 0, 0);
    step("R2 fcsr off",     1, 2'b01, 12'h003, 2'b10, 5'd0, 2'b00, 0, 0, 0, 0);
    step("R9 trapped wr",   1, 2'b01, 12'h001, 2'b01, 5'd4, 2'b00, 0, 0, 0, 0);
    step("R10 off ignored", 0, 2'b00, 12'h000, 2'b00, 5'd0, 2'b00, 0, 0, 0, 1);
    step("R4 ro read",      1, 2'b01, 12'hC00, 2'b11, 5'd0, 2'b00, 0, 1, 2'b01, 0);
    step("R3 ro write",     1, 2'b01, 12'hC00, 2'b10, 5'd7, 2'b00, 0, 0, 0, 0);
    step("R3 ro swap",      1, 2'b01, 12'hF14, 2'b01, 5'd0, 2'b11, 0, 0, 0, 0);
    step("R5 low priv",     1, 2'b01, 12'h300, 2'b10, 5'd0, 2'b01, 0, 0, 0, 0);
    step("R5 enough priv",  1, 2'b01, 12'h300, 2'b10, 5'd0, 2'b11, 0, 0, 0, 0);
    step("R5 S on S csr",   1, 2'b01, 12'h180, 2'b01, 5'd1, 2'b01, 0, 0, 0, 0);
    step("R6 wfi tw S",     1, 2'b11, 12'h000, 2'b00, 5'd0, 2'b01, 1, 0, 0, 0);
    step("R6 wfi no tw",    1, 2'b11, 12'h000, 2'b00, 5'd0, 2'b00, 0, 0, 0, 0);
    step("R6 wfi tw M",     1, 2'b11, 12'h000, 2'b00, 5'd0, 2'b11, 1, 0, 0, 0);
    step("R7 not valid",    0, 2'b01, 12'h7C0, 2'b01, 5'd1, 2'b00, 1, 0, 0, 0);
    step("R7 other kind",   1, 2'b00, 12'h7C0, 2'b01, 5'd1, 2'b00, 1, 0, 0, 0);
    step("R9 fflags wr",    1, 2'b01, 12'h001, 2'b01, 5'd0, 2'b00, 0, 0, 0, 0);
    step("R11 load",        0, 2'b00, 12'h000, 2'b00, 5'd0, 2'b00, 0, 1, 2'b10, 0);
    step("R10 rf dirty",    0, 2'b00, 12'h000, 2'b00, 5'd0, 2'b00, 0, 0, 0, 1);
    step("R11 dirty wins",  1, 2'b01, 12'h002, 2'b10, 5'd2, 2'b00, 0, 1, 2'b01, 0);
    step("R9 frm read",     1, 2'b01, 12'h002, 2'b10, 5'd0, 2'b00, 0, 1, 2'b01, 0);

    for (int i = 0; i < 3000; i++) begin
      int sel;
      logic [1:0] pr;
      sel = $urandom_range(0, 3);
      if (sel < 2) ra = impl_tab[$urandom_range(0, 12)];
      else if (sel == 2) ra = 12'($urandom);
      else ra = {2'b11, 10'($urandom)};
      pr = ($urandom_range(0, 2) == 2) ? 2'b11 : 2'($urandom_range(0, 1));
      step("rand", $urandom_range(0, 7) != 0, 2'($urandom), ra, 2'($urandom),
           ($urandom_range(0, 1) != 0) ? 5'd0 : 5'($urandom), pr,
           1'($urandom), $urandom_range(0, 9) == 0, 2'($urandom),
           $urandom_range(0, 5) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule